// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Port

This block drives a group of output pins from an output register that changes only at chosen trigger instants. A host loads the next pattern into a buffer register at any time; a built-in up-counter with a programmable period produces a compare-match event, and on that event the buffered pattern is copied onto the pins. A per-bit enable mask limits which pins take part in the transfer. The remaining pins keep their value and can be written directly by the host.

The pins are split into groups of four. Each group has its own select field. The field picks the trigger for that group: the local timer's match, or one of several match strobes brought in from other timers. A match of the local timer clears its counter and sets a status flag. When the flag's interrupt enable is set, the flag raises an interrupt request, so a host or DMA engine can supply the next pattern.

A typical use is a stepping-motor phase sequence. The host writes a repeating list of patterns, one per match, and the pins step through overlapping phases with no glitch between matches.

Top module: `tmr_pattern_port`

## Requirements
- R1: After reset the pins, the status flag and the interrupt request are 0, and the counter is stopped, so no transfer happens until the run bit is set.
- R2: While the run bit (control register, address 3, bit 0) is 1, a period value N (address 0) gives a local match every N+1 clock cycles. The first pin update occurs N+1 cycles after the run bit is written. While the run bit is 0 the counter is held at zero.
- R3: On a trigger for a group, every pin of that group whose enable bit (address 2) is 1 takes the value of the same bit of the next-data register (address 1) in the following cycle.
- R4: Pins whose enable bit is 0 are never changed by a transfer. A write to address 5 updates exactly those pins whose enable bit is 0, and leaves enabled pins untouched.
- R5: Writing the next-data register leaves the pins unchanged until the next trigger.
- R6: A local match sets the status flag in the following cycle. Matches from other timers do not set it. The interrupt request is 1 only when the flag is 1 and the interrupt enable (address 3, bit 1) is 1.
- R7: Writing address 4 with bit 0 set clears the flag. If the clear arrives in the same cycle as a local match, the flag stays set.
- R8: Control bits 3:2 select the trigger for pins 3:0, and bits 5:4 select it for pins 7:4. Select value 0 is the local match. Select value k (1 to 3) is external match input bit k-1. A group that does not select a strobe is not updated by it.
- R9: With enable 0xF8, the host writes 0x80, 0xC0, 0x40, 0x60, 0x20, 0x30, 0x10, 0x18, 0x08, 0x88 one per match, repeating the list. The pins then step through the same list, always with one or two of pins 7:3 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| ext_match | input | 2**SEL_W-1 | Match strobes from other timers, one-cycle pulses |
| pins | output | DATA_W | Output pattern |
| irq_flag | output | 1 | Match status flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the external match strobes and the write strobe are synchronous single-cycle pulses. They also assume that address 5 is the only way the host changes a disabled pin directly. The stimulus drives every input at the falling edge and holds it for exactly one cycle. It times flag clears against known match instants so that the collision case lands exactly on a match edge. It never writes the period register while the counter runs.

// File: rtl/ppo_pkg.sv
package ppo_pkg;
    localparam logic [2:0] A_PERIOD = 3'd0;
    localparam logic [2:0] A_NEXT   = 3'd1;
    localparam logic [2:0] A_ENABLE = 3'd2;
    localparam logic [2:0] A_CTRL   = 3'd3;
    localparam logic [2:0] A_STATUS = 3'd4;
    localparam logic [2:0] A_OUTPUT = 3'd5;

    localparam int CTL_RUN    = 0;
    localparam int CTL_IRQEN  = 1;
    localparam int CTL_SEL_LO = 2;
endpackage

// File: rtl/ppo_timer.sv
module ppo_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic             match
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        match = run && (cur_q.cnt == period);
        if (!run || match) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/ppo_xfer.sv
module ppo_xfer #(
    parameter int DATA_W  = 8,
    parameter int GROUP_W = 4,
    parameter int SEL_W   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               own_match,
    input  logic [(2**SEL_W)-2:0]              ext_match,
    input  logic [(DATA_W/GROUP_W)*SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0]                  next_data,
    input  logic [DATA_W-1:0]                  enable,
    input  logic                               dir_we,
    input  logic [DATA_W-1:0]                  dir_data,
    output logic [DATA_W-1:0]                  pins
);
    localparam int NGRP = DATA_W / GROUP_W;
    localparam int NSRC = 2 ** SEL_W;

    typedef struct packed {
        logic [DATA_W-1:0] out;
    } xfer_t;

    xfer_t cur_q, nxt_d;
    logic [NSRC-1:0] src;
    logic [NGRP-1:0] trig;

    assign src = {ext_match, own_match};

    for (genvar g = 0; g < NGRP; g++) begin : g_trig
        logic [SEL_W-1:0] s;
        assign s       = sel[g*SEL_W +: SEL_W];
        assign trig[g] = src[s];
    end

    always_comb begin
        nxt_d = cur_q;
        for (int i = 0; i < DATA_W; i++) begin
            if (enable[i]) begin
                if (trig[i / GROUP_W]) nxt_d.out[i] = next_data[i];
            end else if (dir_we) begin
                nxt_d.out[i] = dir_data[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pins = cur_q.out;
endmodule

// File: rtl/tmr_pattern_port.sv
module tmr_pattern_port #(
    parameter int DATA_W  = 8,
    parameter int GROUP_W = 4,
    parameter int SEL_W   = 2,
    parameter int CNT_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic [(2**SEL_W)-2:0] ext_match,
    output logic [DATA_W-1:0]     pins,
    output logic                  irq_flag,
    output logic                  irq
);
    import ppo_pkg::*;

    localparam int NGRP   = DATA_W / GROUP_W;
    localparam int SELS_W = NGRP * SEL_W;

    typedef struct packed {
        logic [CNT_W-1:0]  period;
        logic [DATA_W-1:0] next;
        logic [DATA_W-1:0] en;
        logic              run;
        logic              irq_en;
        logic [SELS_W-1:0] sel;
        logic              flag;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic  tmr_match;
    logic  dir_we;
    logic  run_w;
    logic [DATA_W-1:0] en_w;

    assign run_w = cur_q.run;
    assign en_w  = cur_q.en;

    always_comb begin
        nxt_d  = cur_q;
        dir_we = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_PERIOD: nxt_d.period = wr_data;
                A_NEXT:   nxt_d.next   = wr_data[DATA_W-1:0];
                A_ENABLE: nxt_d.en     = wr_data[DATA_W-1:0];
                A_CTRL: begin
                    nxt_d.run    = wr_data[CTL_RUN];
                    nxt_d.irq_en = wr_data[CTL_IRQEN];
                    nxt_d.sel    = wr_data[CTL_SEL_LO +: SELS_W];
                end
                A_OUTPUT: dir_we = 1'b1;
                default: ;
            endcase
        end
        if (tmr_match) begin
            nxt_d.flag = 1'b1;
        end else if (wr_en && wr_addr == A_STATUS && wr_data[0]) begin
            nxt_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    ppo_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_w),
        .period (cur_q.period),
        .match  (tmr_match)
    );

    ppo_xfer #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .SEL_W(SEL_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_match (tmr_match),
        .ext_match (ext_match),
        .sel       (cur_q.sel),
        .next_data (cur_q.next),
        .enable    (en_w),
        .dir_we    (dir_we),
        .dir_data  (wr_data[DATA_W-1:0]),
        .pins      (pins)
    );

    assign irq_flag = cur_q.flag;
    assign irq      = cur_q.flag & cur_q.irq_en;
endmodule

// File: rtl/ppo_checks.sv
module ppo_checks #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2,
    parameter int CNT_W  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [2:0]            wr_addr,
    input logic [CNT_W-1:0]      wr_data,
    input logic [(2**SEL_W)-2:0] ext_match,
    input logic [DATA_W-1:0]     pins,
    input logic                  irq_flag,
    input logic                  match,
    input logic                  run,
    input logic [DATA_W-1:0]     enable
);
    import ppo_pkg::*;

    logic clr_wr, dir_wr;
    assign clr_wr = wr_en && wr_addr == A_STATUS && wr_data[0];
    assign dir_wr = wr_en && wr_addr == A_OUTPUT;

    AST_NO_MATCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !match); // R2

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq_flag); // R6

    AST_FLAG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !clr_wr) |=> irq_flag); // R7

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !match) |=> !irq_flag); // R7

    AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && ext_match == '0 && !dir_wr) |=> $stable(pins)); // R5

    AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_wr |=> (((pins ^ $past(pins)) & ~$past(enable)) == '0)); // R4
endmodule

bind tmr_pattern_port ppo_checks #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ext_match (ext_match),
    .pins      (pins),
    .irq_flag  (irq_flag),
    .match     (tmr_match),
    .run       (run_w),
    .enable    (en_w)
);

// File: tb/sim_tmr_pattern_port.sv
module sim_tmr_pattern_port;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [2:0]    ext_match = '0;
    logic [7:0]    pins;
    logic          irq_flag;
    logic          irq;

    int checks = 0;
    int errors = 0;

    tmr_pattern_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_match(ext_match), .pins(pins),
        .irq_flag(irq_flag), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ext(input int k);
        ext_match[k] = 1'b1;
        @(negedge clk);
        ext_match = '0;
    endtask

    task automatic wait_flag(input string req);
        int k = 0;
        while (!irq_flag && k < 100) begin
            @(negedge clk);
            k++;
        end
        check(req, int'(irq_flag), 1);
    endtask

    function automatic logic [7:0] seq_val(input int i);
        case (i % 10)
            0: return 8'h80; 1: return 8'hC0; 2: return 8'h40; 3: return 8'h60;
            4: return 8'h20; 5: return 8'h30; 6: return 8'h10; 7: return 8'h18;
            8: return 8'h08; default: return 8'h88;
        endcase
    endfunction

    task automatic t_reset();
        check("R1 pins", int'(pins), 0);
        check("R1 flag", int'(irq_flag), 0);
        check("R1 irq", int'(irq), 0);
        wr(3'd1, 16'h00FF);
        wr(3'd2, 16'h00FF);
        repeat (10) @(negedge clk);
        check("R1 stopped no transfer", int'(pins), 0);
    endtask

    task automatic t_period();
        int n = 0;
        wr(3'd0, 16'd4);
        wr(3'd3, 16'h0001);
        while (pins == 8'h00 && n < 50) begin @(negedge clk); n++; end
        check("R2 first match delay", n, 5);
        check("R3 transfer", int'(pins), 8'hFF);
        check("R6 flag set", int'(irq_flag), 1);
        check("R6 irq masked", int'(irq), 0);
        wr(3'd1, 16'h0000);
        n = 0;
        while (pins == 8'hFF && n < 50) begin @(negedge clk); n++; end
        check("R5 R2 held until next match", n, 4);
        check("R3 second transfer", int'(pins), 8'h00);
        wr(3'd3, 16'h0003);
        check("R6 irq enabled", int'(irq), 1);
        wr(3'd3, 16'h0002);
        wr(3'd4, 16'h0001);
        check("R7 clear", int'(irq_flag), 0);
        check("R6 irq after clear", int'(irq), 0);
    endtask

    task automatic t_collide();
        wr(3'd0, 16'd3);
        wr(3'd1, 16'h0011);
        wr(3'd3, 16'h0001);
        wait_flag("R7 first flag");
        repeat (3) @(negedge clk);
        wr(3'd4, 16'h0001);
        check("R7 set wins", int'(irq_flag), 1);
        wr(3'd4, 16'h0001);
        check("R7 later clear", int'(irq_flag), 0);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0001);
        check("R3 pattern", int'(pins), 8'h11);
    endtask

    task automatic t_mask();
        wr(3'd2, 16'h000F);
        wr(3'd5, 16'h00F3);
        check("R4 direct write", int'(pins), 8'hF1);
        wr(3'd1, 16'h00A6);
        wr(3'd0, 16'd2);
        wr(3'd3, 16'h0001);
        wait_flag("R4 flag");
        check("R4 masked transfer", int'(pins), 8'hF6);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0001);
    endtask

    task automatic t_groups();
        wr(3'd2, 16'h00FF);
        wr(3'd1, 16'h005A);
        wr(3'd3, 16'h0014);
        pulse_ext(0);
        check("R8 ext both groups", int'(pins), 8'h5A);
        check("R6 ext no flag", int'(irq_flag), 0);
        wr(3'd1, 16'h00C3);
        wr(3'd3, 16'h0024);
        pulse_ext(0);
        check("R8 low group only", int'(pins), 8'h53);
        pulse_ext(1);
        check("R8 high group ext1", int'(pins), 8'hC3);
        wr(3'd1, 16'h000F);
        wr(3'd0, 16'd2);
        wr(3'd3, 16'h0031);
        wait_flag("R8 own flag");
        check("R8 own match low only", int'(pins), 8'hCF);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0001);
    endtask

    task automatic t_phase();
        wr(3'd2, 16'h00F8);
        wr(3'd5, 16'h0000);
        check("R4 low bits cleared", int'(pins), 8'hC8);
        wr(3'd0, 16'd3);
        wr(3'd1, 16'h0080);
        wr(3'd3, 16'h0001);
        for (int i = 0; i < 20; i++) begin
            wait_flag("R9 match");
            check("R9 pattern", int'(pins), int'(seq_val(i)));
            check("R9 one or two phases",
                  int'(($countones(pins[7:3]) >= 1) && ($countones(pins[7:3]) <= 2)), 1);
            wr(3'd4, 16'h0001);
            wr(3'd1, {8'h00, seq_val(i + 1)});
        end
        wr(3'd3, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_collide();
        t_mask();
        t_groups();
        t_phase();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule